// File: doc/BRIEF.md
# Daisy-Chainable Serial Command Target

This block is the serial front end of a peripheral that takes fixed-width command words from a host over a four-wire serial link. While selected, it takes in one bit on every falling serial clock edge, most significant bit first. On every rising edge it drives one bit out. For the first word-length of rising edges, the outgoing bits are a status word. After that, the outgoing bits are the incoming bits, each delayed by one word length. Several targets can therefore share one select line, with the serial output of one wired to the serial input of the next.

When the select line is released, the block checks how many bits the frame held. If the count is a non-zero multiple of the word width, the last full word received is handed to the command side with a one-cycle valid strobe. Any other count leaves the command output untouched. All pins are brought into the system clock domain through a synchronizer, and all of the logic runs on that one clock. Because of this, the serial clock must stay at each level for at least three system clock cycles. The block decodes none of the command bits.

Top module: `spi_chain_target`

## Requirements
- R1: A synchronous active-high reset clears `cmd_word` to 0 and drives `cmd_valid`, `spi_so` and `spi_so_oe` low. If reset arrives in the middle of a frame, a select release that follows with no further serial clocks delivers no command.
- R2: Serial input is sampled on serial clock falling edges, most significant bit first. A delivered command equals the last 16 bits received, and the earliest of those 16 lands in bit 15 of `cmd_word`.
- R3: `spi_so` changes only on serial clock rising edges. From the start of a frame until the first rising edge, `spi_so_oe` is 1 and `spi_so` is 0.
- R4: On rising edges 1 to 16 of a frame, `spi_so` shows the status word, starting at bit 15 and ending at bit 0.
- R5: On rising edge 16+k+1 (k counted from 0), `spi_so` shows the bit that was received on falling edge k+1, which gives daisy-chain forwarding with a 16-clock delay.
- R6: When the select line rises after a frame of 16, 32 or 48 bits, `cmd_valid` is high for exactly one system clock cycle. `cmd_word` takes its new value in that same cycle.
- R7: When the select line rises after a frame whose bit count is 0 or not a multiple of 16, `cmd_valid` stays low and `cmd_word` keeps its previous value.
- R8: While the select line is high, toggling the serial clock and serial input has no effect: `spi_so_oe` stays 0, no command is delivered, and `cmd_word` does not change.
- R9: The status word is captured when the select line falls. Changes on `status_word` during the frame do not alter the bits shifted out.
- R10: `cmd_word` changes only in a cycle where `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Select, active low |
| spi_si | input | 1 | Serial data from the host or the upstream target |
| status_word | input | 16 | Word reported on the first 16 outgoing bits |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the serial output pad (1 = driven) |
| cmd_word | output | 16 | Last accepted command word |
| cmd_valid | output | 1 | One-cycle strobe marking a new `cmd_word` |

## Verification
The hardest cases to reach from the ports are the frame-length boundaries: a 15-bit or 17-bit frame must be rejected, while 16 and 32 bits must be accepted. Reaching these needs exact control of how many serial clocks fall inside one select window. The stimulus therefore sweeps every frame length from 0 to 49 bits. Each frame uses fresh pseudo-random data and a fresh status word, and the status input is flipped partway through the frame. Every outgoing bit is checked against the status-then-delayed-input rule. A reset asserted in the middle of a frame and a burst of clocks with the target deselected cover the remaining paths.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int unsigned DEF_WORD_W = 16;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dly
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {(STAGES+1){RST_VAL[b]}};
      else     chain <= {chain[STAGES-1:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
    assign dly[b]  = chain[STAGES];
  end
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det
  import spi_chain_pkg::*;
(
  input  logic  sclk_now,
  input  logic  sclk_old,
  input  logic  csn_now,
  input  logic  csn_old,
  output edge_t sclk_e,
  output edge_t csn_e,
  output logic  sel
);
  always_comb begin
    sclk_e.rise = sclk_now & ~sclk_old;
    sclk_e.fall = ~sclk_now & sclk_old;
    csn_e.rise  = csn_now & ~csn_old;
    csn_e.fall  = ~csn_now & csn_old;
    sel         = ~csn_now;
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_chain_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  edge_t             sclk_e,
  input  edge_t             csn_e,
  input  logic              si_bit,
  input  logic [WORD_W-1:0] status_in,
  output logic              so_q,
  output logic              oe_q,
  output logic [WORD_W-1:0] cmd_q,
  output logic              vld_q
);
  localparam int unsigned CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              full;
  logic              frame_ok;

  assign frame_ok = full && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
      full  <= 1'b0;
      so_q  <= 1'b0;
      oe_q  <= 1'b0;
      cmd_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (csn_e.fall) begin
        shreg <= status_in;
        cnt   <= '0;
        full  <= 1'b0;
        so_q  <= 1'b0;
        oe_q  <= 1'b1;
      end else if (csn_e.rise) begin
        oe_q <= 1'b0;
        if (frame_ok) begin
          cmd_q <= shreg;
          vld_q <= 1'b1;
        end
      end else if (sel) begin
        if (sclk_e.rise) so_q <= shreg[WORD_W-1];
        if (sclk_e.fall) begin
          shreg <= {shreg[WORD_W-2:0], si_bit};
          if (cnt == LAST) begin
            cnt  <= '0;
            full <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R6
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);
  // R6
  vld_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> !oe_q);
  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> $stable(cmd_q));
  // R3
  so_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !so_q);
  // R8
  so_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel && !oe_q) |=> $stable(so_q));
endmodule

// File: rtl/spi_chain_target.sv
module spi_chain_target
  import spi_chain_pkg::*;
#(
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic [WORD_W-1:0] status_word,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_valid
);
  localparam int unsigned PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b010;

  logic [PIN_N-1:0] pins_raw, pins_now, pins_old;
  edge_t            sclk_e, csn_e;
  logic             sel;
  logic             sync_unused;

  assign pins_raw    = {spi_si, spi_cs_n, spi_sclk};
  assign sync_unused = pins_old[2];

  spi_pin_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pins_raw),
    .dout(pins_now),
    .dly (pins_old)
  );

  spi_edge_det u_edge (
    .sclk_now(pins_now[0]),
    .sclk_old(pins_old[0]),
    .csn_now (pins_now[1]),
    .csn_old (pins_old[1]),
    .sclk_e  (sclk_e),
    .csn_e   (csn_e),
    .sel     (sel)
  );

  spi_frame_engine #(
    .WORD_W(WORD_W)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .sclk_e   (sclk_e),
    .csn_e    (csn_e),
    .si_bit   (pins_now[2]),
    .status_in(status_word),
    .so_q     (spi_so),
    .oe_q     (spi_so_oe),
    .cmd_q    (cmd_word),
    .vld_q    (cmd_valid)
  );
endmodule

// File: tb/spi_chain_target_tb.sv
module spi_chain_target_tb;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        si = 1'b0;
  logic [15:0] status = 16'h0;
  logic        so, so_oe, cmd_valid;
  logic [15:0] cmd_word;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] lfsr = 32'hACE1_2468;
  logic [63:0] bits;
  logic [15:0] prev_cmd = 16'h0;

  always #10 clk = ~clk;

  spi_chain_target u_dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_si(si),
    .status_word(status), .spi_so(so), .spi_so_oe(so_oe),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  function automatic logic next_bit();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_and_check(input bit exp_vld, input logic [15:0] exp_word, input string req);
    int pulses = 0;
    logic [15:0] seen = cmd_word;
    cs_n = 1'b1;
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      if (cmd_valid) begin
        pulses++;
        seen = cmd_word;
      end
    end
    chk(pulses == (exp_vld ? 1 : 0), req, pulses, exp_vld ? 1 : 0);
    chk(cmd_word == exp_word, req, cmd_word, exp_word);
    chk(!so_oe, "R8 so_oe after release", so_oe, 0);
    if (exp_vld) chk(seen == exp_word, "R2 word at strobe", seen, exp_word);
  endtask

  task automatic run_frame(input int len, input logic [15:0] st);
    logic [15:0] exp_word;
    bit          ok_len;
    status = st;
    wait_n(2);
    cs_n = 1'b0;
    wait_n(HALF);
    chk(so_oe == 1'b1, "R3 oe at frame start", so_oe, 1);
    chk(so == 1'b0, "R3 so before first rise", so, 0);
    for (int i = 0; i < len; i++) begin
      logic b;
      logic e;
      b = next_bit();
      bits[i] = b;
      sclk = 1'b1;
      si = b;
      wait_n(HALF);
      if (i == 3) status = ~st;
      if (i < 16) begin
        e = st[15-i];
        chk(so == e, "R4/R9 status bit", so, e);
      end else begin
        e = bits[i-16];
        chk(so == e, "R5 forwarded bit", so, e);
      end
      sclk = 1'b0;
      wait_n(HALF);
      chk(so == e, "R3 so holds on fall", so, e);
    end
    ok_len = (len > 0) && (len % 16 == 0);
    exp_word = prev_cmd;
    if (ok_len) begin
      for (int k = 0; k < 16; k++) exp_word[15-k] = bits[len-16+k];
    end
    release_and_check(ok_len, exp_word, ok_len ? "R6 accepted frame" : "R7 rejected frame");
    prev_cmd = exp_word;
  endtask

  initial begin
    wait_n(5);
    chk(cmd_word == 16'h0, "R1 reset cmd_word", cmd_word, 0);
    chk(!cmd_valid, "R1 reset cmd_valid", cmd_valid, 0);
    chk(!so_oe, "R1 reset so_oe", so_oe, 0);
    chk(!so, "R1 reset so", so, 0);
    rst = 1'b0;
    wait_n(5);
    chk(!so_oe && !cmd_valid, "R1 idle after reset", {so_oe, cmd_valid}, 0);

    // R2 R4 R5 R6 R7 R9: sweep every frame length from 0 to 49
    for (int len = 0; len <= 49; len++) begin
      logic [15:0] st;
      st = 16'h5A00 ^ 16'(len * 16'h0935);
      run_frame(len, st);
    end

    // R8: clocks and data while deselected
    for (int i = 0; i < 20; i++) begin
      sclk = ~sclk;
      si = next_bit();
      wait_n(HALF);
      chk(!so_oe, "R8 oe while deselected", so_oe, 0);
      chk(!cmd_valid, "R8 no strobe while deselected", cmd_valid, 0);
      chk(cmd_word == prev_cmd, "R8 cmd unchanged", cmd_word, prev_cmd);
    end
    sclk = 1'b0;
    wait_n(HALF);
    run_frame(16, 16'hC3A5);

    // R1: reset in mid-frame discards the frame
    status = 16'h1234;
    cs_n = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; si = next_bit(); wait_n(HALF);
      sclk = 1'b0; wait_n(HALF);
    end
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    wait_n(HALF);
    prev_cmd = 16'h0;
    release_and_check(1'b0, 16'h0, "R1 mid-frame reset");

    finish_run();
  end
endmodule